// File: doc/BRIEF.md
# Size-Sorted Memory Bank Mapper

This block places up to four memory modules inside a 4 GB cacheable address window. Each slot reports whether a module is fitted and a 3-bit size code. On a start pulse the block captures that configuration. It orders the populated slots from the largest module to the smallest, breaking ties by the lower slot number. It then walks the ordered list and gives each module a base and a limit, with every base equal to the sum of the sizes placed before it. Because sizes are powers of two and arrive in descending order, every base is aligned to its own module size.

Once the mapping is complete a done flag rises. From then on a physical address is decoded every cycle, without a register in the path, into a one-hot slot select and a module-relative offset, or into a miss. If the fitted modules add up to more than the window, an overflow flag is raised. Any module that would reach past the top of the window is left unmapped and is never selected.

Top module: `bank_size_mapper`

## Requirements
- R1: While reset is held and after its release, done, overflow, slot_mapped and sel are all 0, and miss is 1.
- R2: A slot is populated only when its present bit is 1 and its size code is nonzero. Code c (1..7) means 2^(24+c) bytes, so code 1 is 32 MB and code 7 is 2 GB. Code 0, or a present bit of 0, means an empty slot.
- R3: Present bits and size codes are captured on the clock edge that samples start high. done goes low on the next edge and goes high exactly NUM_SLOTS edges after the start edge. A new start always restarts the mapping, including while a previous mapping is still running.
- R4: Populated modules are placed in descending size order starting at address 0. Each base is the sum of the sizes of the modules placed before it, and each mapped base is a multiple of its module size.
- R5: Among modules of equal size, the lower-numbered slot receives the lower address range.
- R6: If the populated sizes sum to more than 4 GB, overflow is 1 and every module whose range would extend past 4 GB is left unmapped. Otherwise overflow is 0 and every populated module is mapped. A sum of exactly 4 GB is not an overflow.
- R7: While done is 1, an address inside a mapped module's range [base, base+size) sets the one-hot sel bit of that slot, sets offset to address minus base, and sets miss to 0.
- R8: An address outside every mapped range, or any address while done is 0, gives miss 1, sel 0 and offset 0.
- R9: Changes on the present and size inputs without a start have no effect on the mapping.
- R10: In the cycle where start is high, decode still uses the previous mapping. From the next cycle every address misses until done rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture configuration and begin mapping |
| present_i | input | NUM_SLOTS | Per-slot module fitted flag |
| size_code_i | input | NUM_SLOTS*SIZE_W | Per-slot size code, slot i at bits [i*SIZE_W +: SIZE_W] |
| addr_i | input | ADDR_W | Physical address to decode |
| done_o | output | 1 | Mapping complete; decode valid |
| overflow_o | output | 1 | Populated sizes exceed the window |
| slot_mapped_o | output | NUM_SLOTS | Per-slot mapped flag |
| slot_base_o | output | NUM_SLOTS*ADDR_W | Per-slot base address, 0 when unmapped |
| sel_o | output | NUM_SLOTS | One-hot slot select of the decoded address |
| offset_o | output | ADDR_W | Address relative to the selected module base |
| miss_o | output | 1 | Address not inside any mapped module |

## Verification
The two functions that can meet in one cycle are decode of a live address and a restart of the mapping. The bench raises start while addr_i points inside a mapped module. Outputs are sampled before the edge, where the old mapping must still give a hit, and again after the edge, where a miss is required until done rises. A second start issued during a running mapping covers the case where an unfinished mapping is overtaken. The behavioural model keeps a count of pending steps and a sorted copy of the configuration, and it checks done timing and every decode output each cycle.

// File: rtl/bsm_pkg.sv
// Shared types and helpers for the size-sorted bank mapper.
// Assumes size codes are small (under 8 bits) and that sizes are powers of two.
package bsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } alloc_state_t;

    // Converts a size code into a byte count; code 0 gives zero bytes.
    function automatic logic [63:0] code_bytes(input logic [7:0] code,
                                               input int unsigned min_shift);
        if (code == 8'd0) begin
            return 64'd0;
        end
        return 64'd1 << (min_shift + 32'(code) - 32'd1);
    endfunction

endpackage

// File: rtl/bsm_cfg_latch.sv
// Configuration capture: holds each slot's size code, taken when start is high.
// A slot with its present bit low is stored as code 0, so later logic sees a
// single "occupied" condition. Assumes start is a one-cycle pulse or a held level.
module bsm_cfg_latch #(
    parameter int NUM_SLOTS = 4,
    parameter int SIZE_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_SLOTS-1:0]        present_i,
    input  logic [NUM_SLOTS*SIZE_W-1:0] size_code_i,
    output logic [NUM_SLOTS*SIZE_W-1:0] code_o,
    output logic [NUM_SLOTS-1:0]        occ_o
);

    logic [NUM_SLOTS*SIZE_W-1:0] code_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Capture this slot's code on start, forcing empty slots to code 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[i*SIZE_W +: SIZE_W] <= '0;
            end else if (start_i) begin
                code_q[i*SIZE_W +: SIZE_W] <= present_i[i] ? size_code_i[i*SIZE_W +: SIZE_W]
                                                            : '0;
            end
        end

        assign occ_o[i] = |code_q[i*SIZE_W +: SIZE_W];
    end

    assign code_o = code_q;

endmodule

// File: rtl/bsm_rank.sv
// Placement rank: for every occupied slot, counts the occupied slots that come
// before it (strictly larger code, or equal code in a lower slot). Ranks of
// occupied slots are therefore unique and dense from 0. Purely combinational.
module bsm_rank #(
    parameter int NUM_SLOTS = 4,
    parameter int SIZE_W    = 3,
    parameter int RANK_W    = 2
) (
    input  logic [NUM_SLOTS*SIZE_W-1:0] code_i,
    input  logic [NUM_SLOTS-1:0]        occ_i,
    output logic [NUM_SLOTS*RANK_W-1:0] rank_o
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [RANK_W-1:0] cnt;

        // Count the occupied slots that must be placed ahead of slot i.
        always_comb begin
            cnt = '0;
            for (int j = 0; j < NUM_SLOTS; j++) begin
                if (j != i && occ_i[j]) begin
                    if ((code_i[j*SIZE_W +: SIZE_W] > code_i[i*SIZE_W +: SIZE_W]) ||
                        ((code_i[j*SIZE_W +: SIZE_W] == code_i[i*SIZE_W +: SIZE_W]) && (j < i))) begin
                        cnt = cnt + 1'b1;
                    end
                end
            end
        end

        assign rank_o[i*RANK_W +: RANK_W] = cnt;
    end

endmodule

// File: rtl/bsm_alloc.sv
// Sequential allocator: after start it spends one cycle per rank position,
// gives the slot holding that rank the running base and adds its size. A module
// that would cross the window top is skipped and flags overflow. In descending
// order a skipped module implies that no later one fits either.
// Assumes code/rank inputs are stable from the edge after start onward.
module bsm_alloc
    import bsm_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SIZE_W    = 3,
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 25,
    parameter int RANK_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [NUM_SLOTS*SIZE_W-1:0]     code_i,
    input  logic [NUM_SLOTS-1:0]            occ_i,
    input  logic [NUM_SLOTS*RANK_W-1:0]     rank_i,
    output logic [NUM_SLOTS*ADDR_W-1:0]     base_o,
    output logic [NUM_SLOTS*(ADDR_W+1)-1:0] limit_o,
    output logic [NUM_SLOTS-1:0]            mapped_o,
    output logic                            done_o,
    output logic                            overflow_o
);

    localparam int LEN_W = ADDR_W + 2;
    localparam logic [LEN_W-1:0] WIN_BYTES = {{(LEN_W-1){1'b0}}, 1'b1} << ADDR_W;
    localparam logic [RANK_W-1:0] LAST_STEP = RANK_W'(NUM_SLOTS - 1);

    alloc_state_t       state_q;
    logic [RANK_W-1:0]  step_q;
    logic [LEN_W-1:0]   acc_q;
    logic [ADDR_W-1:0]  base_q  [NUM_SLOTS];
    logic [ADDR_W:0]    limit_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] mapped_q;
    logic               ovf_q;

    logic               pick_vld;
    logic [RANK_W-1:0]  pick_idx;
    logic [LEN_W-1:0]   pick_size;
    logic [LEN_W-1:0]   next_acc;
    logic               fits;

    // Find the occupied slot whose rank equals the current step.
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (occ_i[i] && (rank_i[i*RANK_W +: RANK_W] == step_q)) begin
                pick_vld = 1'b1;
                pick_idx = RANK_W'(i);
            end
        end
    end

    // Size of the picked module and whether it still fits below the window top.
    always_comb begin
        pick_size = LEN_W'(code_bytes(8'(code_i[pick_idx*SIZE_W +: SIZE_W]), MIN_SHIFT));
        next_acc  = acc_q + pick_size;
        fits      = (next_acc <= WIN_BYTES);
    end

    // Step through the ranks once per cycle and record base, limit and mapped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            acc_q    <= '0;
            mapped_q <= '0;
            ovf_q    <= 1'b0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
            end
        end else if (start_i) begin
            state_q  <= ST_BUSY;
            step_q   <= '0;
            acc_q    <= '0;
            mapped_q <= '0;
            ovf_q    <= 1'b0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
            end
        end else if (state_q == ST_BUSY) begin
            if (pick_vld) begin
                if (fits) begin
                    base_q[pick_idx]   <= acc_q[ADDR_W-1:0];
                    limit_q[pick_idx]  <= next_acc[ADDR_W:0];
                    mapped_q[pick_idx] <= 1'b1;
                    acc_q              <= next_acc;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (step_q == LAST_STEP) begin
                state_q <= ST_DONE;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_out
        logic [LEN_W-1:0] slot_size;

        assign base_o[i*ADDR_W +: ADDR_W]         = base_q[i];
        assign limit_o[i*(ADDR_W+1) +: ADDR_W+1]  = limit_q[i];
        assign slot_size = LEN_W'(code_bytes(8'(code_i[i*SIZE_W +: SIZE_W]), MIN_SHIFT));

        // R4: a mapped base sits on a boundary of its own module size.
        assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && mapped_q[i]) |-> ((LEN_W'(base_q[i]) & (slot_size - 1'b1)) == '0));

        // R6: no mapped module reaches past the top of the window.
        assert_inside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && mapped_q[i]) |-> (limit_q[i] <= WIN_BYTES[ADDR_W:0]));
    end

    assign mapped_o   = mapped_q;
    assign done_o     = (state_q == ST_DONE);
    assign overflow_o = ovf_q;

    // R3: a start always drops done on the following edge.
    assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    // R6: without overflow every occupied slot ends up mapped.
    assert_full_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !overflow_o) |-> (mapped_q == occ_i));

endmodule

// File: rtl/bsm_decode.sv
// Address decoder: compares the address with every mapped range in parallel and
// returns a one-hot select, the module-relative offset and a miss flag. Only
// active while the mapping is done. Assumes mapped ranges do not overlap.
module bsm_decode #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            done_i,
    input  logic [NUM_SLOTS-1:0]            mapped_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]     base_i,
    input  logic [NUM_SLOTS*(ADDR_W+1)-1:0] limit_i,
    input  logic [ADDR_W-1:0]               addr_i,
    output logic [NUM_SLOTS-1:0]            sel_o,
    output logic [ADDR_W-1:0]               offset_o,
    output logic                            miss_o
);

    logic [NUM_SLOTS-1:0] hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hit[i] = done_i && mapped_i[i] &&
                        (addr_i >= base_i[i*ADDR_W +: ADDR_W]) &&
                        ({1'b0, addr_i} < limit_i[i*(ADDR_W+1) +: ADDR_W+1]);
    end

    // Form the offset from the base of whichever slot hit.
    always_comb begin
        offset_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) begin
                offset_o = offset_o | (addr_i - base_i[i*ADDR_W +: ADDR_W]);
            end
        end
    end

    assign sel_o  = hit;
    assign miss_o = ~|hit;

    // R7: the allocator never produces overlapping ranges, so at most one select.
    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

endmodule

// File: rtl/bank_size_mapper.sv
// Top level of the size-sorted bank mapper. Captures the slot configuration on
// start, ranks the slots by size (lower slot first on ties), assigns bases over
// NUM_SLOTS cycles and decodes addresses once done. Assumes a window of
// 2^ADDR_W bytes and size codes meaning 2^(MIN_SHIFT-1+code) bytes.
module bank_size_mapper #(
    parameter int NUM_SLOTS = 4,
    parameter int SIZE_W    = 3,
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 25
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_SLOTS-1:0]        present_i,
    input  logic [NUM_SLOTS*SIZE_W-1:0] size_code_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic                        done_o,
    output logic                        overflow_o,
    output logic [NUM_SLOTS-1:0]        slot_mapped_o,
    output logic [NUM_SLOTS*ADDR_W-1:0] slot_base_o,
    output logic [NUM_SLOTS-1:0]        sel_o,
    output logic [ADDR_W-1:0]           offset_o,
    output logic                        miss_o
);

    localparam int RANK_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [NUM_SLOTS*SIZE_W-1:0]     code;
    logic [NUM_SLOTS-1:0]            occ;
    logic [NUM_SLOTS*RANK_W-1:0]     rank;
    logic [NUM_SLOTS*ADDR_W-1:0]     base;
    logic [NUM_SLOTS*(ADDR_W+1)-1:0] limit;
    logic [NUM_SLOTS-1:0]            mapped;
    logic                            done;

    bsm_cfg_latch #(
        .NUM_SLOTS(NUM_SLOTS),
        .SIZE_W   (SIZE_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .present_i  (present_i),
        .size_code_i(size_code_i),
        .code_o     (code),
        .occ_o      (occ)
    );

    bsm_rank #(
        .NUM_SLOTS(NUM_SLOTS),
        .SIZE_W   (SIZE_W),
        .RANK_W   (RANK_W)
    ) u_rank (
        .code_i(code),
        .occ_i (occ),
        .rank_o(rank)
    );

    bsm_alloc #(
        .NUM_SLOTS(NUM_SLOTS),
        .SIZE_W   (SIZE_W),
        .ADDR_W   (ADDR_W),
        .MIN_SHIFT(MIN_SHIFT),
        .RANK_W   (RANK_W)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .code_i    (code),
        .occ_i     (occ),
        .rank_i    (rank),
        .base_o    (base),
        .limit_o   (limit),
        .mapped_o  (mapped),
        .done_o    (done),
        .overflow_o(overflow_o)
    );

    bsm_decode #(
        .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .mapped_i(mapped),
        .base_i  (base),
        .limit_i (limit),
        .addr_i  (addr_i),
        .sel_o   (sel_o),
        .offset_o(offset_o),
        .miss_o  (miss_o)
    );

    assign done_o        = done;
    assign slot_mapped_o = mapped;
    assign slot_base_o   = base;

endmodule

// File: tb/tb_bank_size_mapper.sv
// Bench for bank_size_mapper: a behavioural model (sorted list, running sum,
// pending-step counter) is advanced on every edge and compared every cycle.
module tb_bank_size_mapper;

    localparam int N  = 4;
    localparam int SW = 3;
    localparam int AW = 32;
    localparam longint WIN = 64'h1_0000_0000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n   = 1'b0;
    logic            start   = 1'b0;
    logic [N-1:0]    present = '0;
    logic [N*SW-1:0] codes   = '0;
    logic [AW-1:0]   addr    = '0;

    logic            done, overflow, miss;
    logic [N-1:0]    mapped, sel;
    logic [N*AW-1:0] bases;
    logic [AW-1:0]   offset;

    bank_size_mapper #(.NUM_SLOTS(N), .SIZE_W(SW), .ADDR_W(AW), .MIN_SHIFT(25)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .present_i(present),
        .size_code_i(codes), .addr_i(addr), .done_o(done), .overflow_o(overflow),
        .slot_mapped_o(mapped), .slot_base_o(bases), .sel_o(sel),
        .offset_o(offset), .miss_o(miss)
    );

    // Reference model state
    bit     m_done, m_ovf, p_ovf;
    int     m_cnt;
    bit     m_map[N], p_map[N];
    longint m_base[N], p_base[N], m_size[N], p_size[N];

    int    checks = 0;
    int    fails  = 0;
    string phase  = "init";

    function automatic longint sz(int c);
        if (c == 0) return 0;
        return longint'(1) << (24 + c);
    endfunction

    // Sort the requested configuration and lay it out (R2, R4, R5, R6).
    task automatic plan_map();
        bit     used[N];
        longint acc = 0;
        p_ovf = 0;
        for (int i = 0; i < N; i++) begin
            used[i]   = 0;
            p_map[i]  = 0;
            p_base[i] = 0;
            p_size[i] = present[i] ? sz(int'(codes[i*SW +: SW])) : 0;
        end
        for (int k = 0; k < N; k++) begin
            int best = -1;
            for (int i = 0; i < N; i++)
                if (!used[i] && p_size[i] > 0 && (best < 0 || p_size[i] > p_size[best])) best = i;
            if (best >= 0) begin
                used[best] = 1;
                if (acc + p_size[best] <= WIN) begin
                    p_map[best]  = 1;
                    p_base[best] = acc;
                    acc += p_size[best];
                end else begin
                    p_ovf = 1;
                end
            end
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_done = 0; m_cnt = 0; m_ovf = 0;
            for (int i = 0; i < N; i++) begin m_map[i] = 0; m_base[i] = 0; m_size[i] = 0; end
        end else if (start) begin
            plan_map();
            m_done = 0;
            m_cnt  = N;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1;
                m_ovf  = p_ovf;
                for (int i = 0; i < N; i++) begin
                    m_map[i] = p_map[i]; m_base[i] = p_base[i]; m_size[i] = p_size[i];
                end
            end
        end
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s] t=%0t: actual %0d expected %0d", req, what, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0] esel = '0;
        longint       eoff = 0;
        bit           emiss = 1;
        chk("R3", "done", longint'(done), longint'(m_done));
        if (m_done) begin
            for (int i = 0; i < N; i++) begin
                if (m_map[i] && longint'(addr) >= m_base[i] && longint'(addr) < m_base[i] + m_size[i]) begin
                    esel[i] = 1'b1;
                    eoff    = longint'(addr) - m_base[i];
                    emiss   = 0;
                end
            end
            chk("R6", "overflow", longint'(overflow), longint'(m_ovf));
            for (int i = 0; i < N; i++) begin
                chk("R4", $sformatf("mapped[%0d]", i), longint'(mapped[i]), longint'(m_map[i]));
                chk("R4", $sformatf("base[%0d]", i), longint'(bases[i*AW +: AW]), m_base[i]);
            end
        end
        chk("R7", "sel", longint'(sel), longint'(esel));
        chk("R7", "offset", longint'(offset), eoff);
        chk("R8", "miss", longint'(miss), longint'(emiss));
    endtask

    // One cycle: compare before the edge, advance the model at the edge.
    task automatic cyc();
        #2;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic probe(longint a);
        addr = AW'(a);
        cyc();
    endtask

    task automatic set_cfg(logic [N-1:0] p, int c3, int c2, int c1, int c0);
        present = p;
        codes   = {SW'(c3), SW'(c2), SW'(c1), SW'(c0)};
    endtask

    task automatic run_start();
        start = 1'b1;
        cyc();
        start = 1'b0;
        for (int k = 0; k < N; k++) cyc();
    endtask

    task automatic sweep();
        for (int i = 0; i < N; i++) begin
            if (m_map[i]) begin
                longint lo = m_base[i];
                longint hi = m_base[i] + m_size[i];
                if (lo > 0) probe(lo - 1);
                probe(lo);
                probe(lo + 64'h123);
                probe(hi - 1);
                if (hi < WIN) probe(hi);
            end
        end
        for (int k = 0; k < 16; k++) probe(longint'($urandom));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3 watchdog expired: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "reset";
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc();
        #2;
        chk("R1", "done", longint'(done), 0);
        chk("R1", "overflow", longint'(overflow), 0);
        chk("R1", "mapped", longint'(mapped), 0);
        chk("R1", "sel", longint'(sel), 0);
        chk("R1", "miss", longint'(miss), 1);
        @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R8: decode before any mapping misses
        phase = "pre-start";
        probe(0);
        probe(64'h4000_0000);

        // R2/R4: mixed sizes; slot 2 has a code but is not present
        phase = "mixed";
        set_cfg(4'b1011, 6, 7, 6, 2);
        run_start();
        sweep();

        // R10: start together with a hitting address; old map used this cycle
        phase = "start-overlap";
        set_cfg(4'b1111, 4, 0, 4, 4);
        addr  = 32'h4000_0010;
        start = 1'b1;
        cyc();
        start = 1'b0;
        addr  = 32'h0000_0010;
        cyc();
        for (int k = 0; k < N - 1; k++) cyc();

        // R5/R2: equal sizes ordered by slot, present slot with code 0 stays empty
        phase = "ties";
        sweep();

        // R3: restart while a mapping is still running
        phase = "restart-busy";
        set_cfg(4'b1111, 1, 7, 6, 7);
        start = 1'b1;
        cyc();
        start = 1'b0;
        cyc();
        cyc();
        run_start();

        // R6: overflow, the two small modules stay unmapped
        phase = "overflow";
        sweep();
        probe(WIN - 1);

        // R9: input changes without start leave the map untouched
        phase = "ignore-inputs";
        set_cfg(4'b0000, 1, 1, 1, 1);
        sweep();
        set_cfg(4'b1111, 2, 3, 4, 5);
        sweep();

        // R6: exact 4 GB total is not an overflow
        phase = "exact-fill";
        set_cfg(4'b1111, 5, 5, 6, 7);
        run_start();
        sweep();
        probe(WIN - 1);

        // R8: no modules at all
        phase = "empty";
        set_cfg(4'b0000, 7, 7, 7, 7);
        run_start();
        probe(0);
        probe(64'hFFFF_FFFF);

        // Smallest modules in reversed slot order
        phase = "small";
        set_cfg(4'b1111, 1, 2, 3, 1);
        run_start();
        sweep();

        summary();
        $finish;
    end

endmodule